// File: doc/BRIEF.md
# Strip-Mining Vector Length Sequencer

This block breaks an application loop of N elements into strips that a vector unit with a fixed maximum vector length can process. A single start pulse carries N. The sequencer then presents one strip at a time on a valid/ready output: a vector length and the index of the first element that strip covers. The strip stays on the output until downstream execution accepts it with ready, and the sequencer then moves on to the next strip. When every element has been covered, a one-cycle done flag marks the end of the job. The block only schedules strips. It performs no vector arithmetic.

The odd-sized part goes first. The opening strip holds N mod MAX_VL elements at index 0, and every strip after it holds exactly MAX_VL elements, each starting where the previous one ended. When N is an exact multiple of MAX_VL, the empty opening strip is skipped, so every strip issued is full. When N is zero, no strip is issued and done follows the start at once.

The controller has three states. SQ_IDLE waits for start. SQ_ISSUE presents the current strip. SQ_FINISH raises done for one cycle. The transitions are:
- T_LAUNCH: SQ_IDLE to SQ_ISSUE, on start with N not zero.
- T_EMPTY: SQ_IDLE to SQ_FINISH, on start with N equal to zero.
- T_NEXT: SQ_ISSUE to SQ_ISSUE, on a handshake while full strips remain.
- T_LAST: SQ_ISSUE to SQ_FINISH, on the handshake of the final strip.
- T_RETIRE: SQ_FINISH to SQ_IDLE, unconditionally.

Top module: `strip_sequencer`

## Requirements
- R1: While reset is held, and after it is released until a start is seen, strip_valid_o and done_o are 0.
- R2: When N mod 64 is not zero, the first strip issued has length N mod 64 and start index 0.
- R3: Every strip after the first has length 64, and its start index equals the previous strip's start index plus the previous strip's length.
- R4: A job issues exactly floor(N/64) strips after the opening remainder strip, and done follows only after all of them have been accepted.
- R5: When N is a non-zero multiple of 64, the first strip has length 64 at index 0, and N/64 strips are issued in total.
- R6: When N is 0, no strip is issued and done_o is 1 in the cycle right after the start edge.
- R7: While strip_valid_o is 1 and strip_ready_i is 0, the strip length and start index keep their values into the next cycle, and valid stays 1.
- R8: done_o is a single-cycle pulse. It rises in the cycle after the final strip is accepted, and it is never 1 together with strip_valid_o.
- R9: A start seen while a job is active, including the cycle of the final handshake and the done cycle, is ignored: no extra strips are issued.
- R10: Whenever strip_valid_o is 1, the strip length lies in the range 1 to 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a job with element count total_i; only honoured in SQ_IDLE |
| total_i | input | 16 | Application element count N, unsigned |
| strip_valid_o | output | 1 | A strip is presented |
| strip_ready_i | input | 1 | Downstream accepts the presented strip |
| strip_len_o | output | 7 | Vector length of the presented strip |
| strip_base_o | output | 16 | Index of the first element of the presented strip |
| done_o | output | 1 | One-cycle pulse at the end of a job |

## Verification
Two events can land in the same cycle here: the handshake that retires the final strip, and a new start request. The bench lines these up for a single-strip job. It keeps ready low, then raises start and ready on the same edge, and afterwards watches that only the original strip was accepted, that done pulses once, and that no further strip appears. A second case holds start high across the start edge and the done cycle of an empty job, and expects exactly one done pulse and no strips.

// File: rtl/strip_seq_pkg.sv
package strip_seq_pkg;

    // Controller states of the strip sequencer
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_FINISH = 2'd2
    } sq_state_e;

endpackage

// File: rtl/strip_plan.sv
// Splits an element count into the opening strip length and the number of
// full strips still to follow it.
module strip_plan #(
    parameter int CNT_W  = 16,
    parameter int MAX_VL = 64,
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic [CNT_W-1:0] total,
    output logic [LEN_W-1:0] first_len,
    output logic [CNT_W-1:0] full_after,
    output logic             empty
);

    localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_VL);
    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_VL);

    logic [CNT_W-1:0] rem;
    logic [CNT_W-1:0] quo;

    always_comb begin
        rem   = total % MAX_C;
        quo   = total / MAX_C;
        empty = (total == '0);
        if (rem != '0) begin
            first_len  = LEN_W'(rem);
            full_after = quo;
        end else begin
            // exact multiple: skip the empty remainder strip
            first_len  = MAX_L;
            full_after = empty ? '0 : quo - CNT_W'(1);
        end
    end

endmodule

// File: rtl/strip_cursor.sv
// Holds the strip being presented and the count of full strips left.
module strip_cursor #(
    parameter int CNT_W  = 16,
    parameter int MAX_VL = 64,
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] first_len,
    input  logic [CNT_W-1:0] full_after,
    input  logic             step,
    output logic [LEN_W-1:0] len,
    output logic [CNT_W-1:0] base,
    output logic             last
);

    localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_VL);

    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] base_q;
    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            base_q <= '0;
            left_q <= '0;
        end else if (load) begin
            len_q  <= first_len;
            base_q <= '0;
            left_q <= full_after;
        end else if (step && (left_q != '0)) begin
            base_q <= base_q + CNT_W'(len_q);
            len_q  <= MAX_L;
            left_q <= left_q - CNT_W'(1);
        end
    end

    assign len  = len_q;
    assign base = base_q;
    assign last = (left_q == '0);

endmodule

// File: rtl/strip_sequencer.sv
module strip_sequencer #(
    parameter int CNT_W  = 16,
    parameter int MAX_VL = 64,
    parameter int LEN_W  = $clog2(MAX_VL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] total_i,
    output logic             strip_valid_o,
    input  logic             strip_ready_i,
    output logic [LEN_W-1:0] strip_len_o,
    output logic [CNT_W-1:0] strip_base_o,
    output logic             done_o
);

    import strip_seq_pkg::*;

    sq_state_e        state_q, state_d;
    logic [LEN_W-1:0] plan_len;
    logic [CNT_W-1:0] plan_after;
    logic             plan_empty;
    logic             cur_last;
    logic             load;
    logic             step;

    strip_plan #(.CNT_W(CNT_W), .MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_plan (
        .total      (total_i),
        .first_len  (plan_len),
        .full_after (plan_after),
        .empty      (plan_empty)
    );

    strip_cursor #(.CNT_W(CNT_W), .MAX_VL(MAX_VL), .LEN_W(LEN_W)) u_cursor (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .first_len  (plan_len),
        .full_after (plan_after),
        .step       (step),
        .len        (strip_len_o),
        .base       (strip_base_o),
        .last       (cur_last)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: begin
                if (start_i) state_d = plan_empty ? SQ_FINISH : SQ_ISSUE; // T_EMPTY / T_LAUNCH
            end
            SQ_ISSUE: begin
                if (strip_ready_i && cur_last) state_d = SQ_FINISH;       // T_LAST
            end
            SQ_FINISH: state_d = SQ_IDLE;                                 // T_RETIRE
            default:   state_d = SQ_IDLE;
        endcase
    end

    // Outputs and cursor controls
    always_comb begin
        strip_valid_o = 1'b0;
        done_o        = 1'b0;
        load          = 1'b0;
        unique case (state_q)
            SQ_IDLE:   load          = start_i && !plan_empty;
            SQ_ISSUE:  strip_valid_o = 1'b1;
            SQ_FINISH: done_o        = 1'b1;
            default:   ;
        endcase
    end

    assign step = strip_valid_o && strip_ready_i;

    // Assertions
    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        strip_valid_o |-> (strip_len_o != '0) && (strip_len_o <= LEN_W'(MAX_VL))); // R10
    AST_HOLD_STRIP: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && !strip_ready_i) |=>
            (strip_valid_o && $stable(strip_len_o) && $stable(strip_base_o))); // R7
    AST_FIRST_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strip_valid_o) |-> (strip_base_o == '0)); // R2
    AST_LATER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && strip_ready_i) |=> (!strip_valid_o || (strip_len_o == LEN_W'(MAX_VL)))); // R3
    AST_BASE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (strip_valid_o && strip_ready_i) |=>
            (!strip_valid_o || (strip_base_o == $past(strip_base_o) + CNT_W'($past(strip_len_o))))); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && strip_valid_o)); // R8
    AST_EMPTY_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        (!strip_valid_o && !done_o && start_i && (total_i == '0)) |=> (done_o && !strip_valid_o)); // R6

endmodule

// File: tb/tb_strip_sequencer.sv
`timescale 1ns/1ps
module tb_strip_sequencer;

    localparam int CNT_W  = 16;
    localparam int MAX_VL = 64;
    localparam int LEN_W  = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [CNT_W-1:0] total_i = '0;
    logic             strip_valid_o;
    logic             strip_ready_i;
    logic [LEN_W-1:0] strip_len_o;
    logic [CNT_W-1:0] strip_base_o;
    logic             done_o;

    always #4 clk = ~clk; // 125 MHz

    strip_sequencer #(.CNT_W(CNT_W), .MAX_VL(MAX_VL)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .total_i(total_i),
        .strip_valid_o(strip_valid_o), .strip_ready_i(strip_ready_i),
        .strip_len_o(strip_len_o), .strip_base_o(strip_base_o), .done_o(done_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    int exp_len[$];
    int exp_base[$];
    int done_cnt = 0;
    int strip_cnt = 0;

    // ready generation: 0 low, 1 high, 2 pseudo-random
    int          rdy_mode = 1;
    logic [15:0] lfsr = 16'hACE1;
    assign strip_ready_i = (rdy_mode == 1) ? 1'b1 : (rdy_mode == 2) ? lfsr[0] : 1'b0;

    always @(posedge clk) begin
        #1 lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Scoreboard monitor, sampling on the falling edge
    bit prev_stall = 0;
    bit prev_done  = 0;
    int prev_len   = 0;
    int prev_base  = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (strip_valid_o) begin
                check(strip_len_o >= 1 && strip_len_o <= MAX_VL, "R10", "len range",
                      int'(strip_len_o), MAX_VL);
                if (prev_stall) begin
                    check(int'(strip_len_o) == prev_len, "R7", "held len", int'(strip_len_o), prev_len);
                    check(int'(strip_base_o) == prev_base, "R7", "held base", int'(strip_base_o), prev_base);
                end
                if (strip_ready_i) begin
                    strip_cnt++;
                    if (exp_len.size() == 0) begin
                        check(0, "R9", "unexpected strip base", int'(strip_base_o), -1);
                    end else begin
                        int el, eb;
                        el = exp_len.pop_front();
                        eb = exp_base.pop_front();
                        check(int'(strip_len_o) == el, (eb == 0) ? "R2" : "R3", "strip len",
                              int'(strip_len_o), el);
                        check(int'(strip_base_o) == eb, (eb == 0) ? "R2" : "R3", "strip base",
                              int'(strip_base_o), eb);
                    end
                end
            end else if (prev_stall) begin
                check(0, "R7", "valid dropped while stalled", 0, 1);
            end
            if (done_o) begin
                done_cnt++;
                check(!prev_done, "R8", "done wider than one cycle", 2, 1);
                check(!strip_valid_o, "R8", "done with valid", 1, 0);
                check(exp_len.size() == 0, "R4", "strips left at done", exp_len.size(), 0);
            end
            prev_stall = strip_valid_o && !strip_ready_i;
            prev_done  = done_o;
            prev_len   = int'(strip_len_o);
            prev_base  = int'(strip_base_o);
        end
    end

    // Driver: push the expected strips for N
    task automatic push_expect(input int n);
        int b;
        b = 0;
        if (n % MAX_VL != 0) begin
            exp_len.push_back(n % MAX_VL);
            exp_base.push_back(0);
            b = n % MAX_VL;
        end
        for (int i = 0; i < n / MAX_VL; i++) begin
            exp_len.push_back(MAX_VL);
            exp_base.push_back(b);
            b += MAX_VL;
        end
    endtask

    task automatic wait_done(input int d0, input string tag);
        int t;
        t = 0;
        while (done_cnt == d0 && t < 5000) begin
            @(negedge clk);
            t++;
        end
        check(done_cnt == d0 + 1, tag, "done count", done_cnt - d0, 1);
    endtask

    task automatic run_job(input int n, input int mode, input string tag);
        int d0, s0;
        d0 = done_cnt;
        s0 = strip_cnt;
        push_expect(n);
        @(posedge clk); #1;
        rdy_mode = mode;
        start_i  = 1'b1;
        total_i  = CNT_W'(n);
        @(posedge clk); #1;
        start_i  = 1'b0;
        wait_done(d0, tag);
        check(strip_cnt - s0 == (n + MAX_VL - 1) / MAX_VL, tag, "strip total",
              strip_cnt - s0, (n + MAX_VL - 1) / MAX_VL);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!strip_valid_o && !done_o, "R1", "outputs in reset", int'({strip_valid_o, done_o}), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!strip_valid_o && !done_o, "R1", "outputs idle after reset", int'({strip_valid_o, done_o}), 0);

        run_job(10, 1, "R2");
        run_job(64, 1, "R5");
        run_job(200, 1, "R4");
        run_job(128, 2, "R5");
        run_job(1, 2, "R2");
        run_job(333, 2, "R3");
        run_job(65535, 1, "R4");

        // R6 with R9: empty job, start held across the done cycle
        begin
            int d0, s0;
            d0 = done_cnt;
            s0 = strip_cnt;
            @(posedge clk); #1;
            start_i = 1'b1;
            total_i = '0;
            @(posedge clk); #1;
            @(negedge clk);
            check(done_o == 1'b1, "R6", "done after empty start", int'(done_o), 1);
            @(posedge clk); #1;
            start_i = 1'b0;
            repeat (6) @(negedge clk);
            check(done_cnt - d0 == 1, "R9", "done pulses for held start", done_cnt - d0, 1);
            check(strip_cnt == s0 && !strip_valid_o, "R6", "strips for N=0", strip_cnt - s0, 0);
        end

        // R9: start arrives in the same cycle as the final handshake
        begin
            int d0;
            d0 = done_cnt;
            push_expect(10);
            @(posedge clk); #1;
            rdy_mode = 0;
            start_i  = 1'b1;
            total_i  = CNT_W'(10);
            @(posedge clk); #1;
            start_i  = 1'b0;
            repeat (3) @(posedge clk);
            #1;
            start_i  = 1'b1;
            total_i  = CNT_W'(3);
            rdy_mode = 1;
            @(posedge clk); #1;
            start_i  = 1'b0;
            wait_done(d0, "R9");
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check(!strip_valid_o, "R9", "strip after ignored start", int'(strip_valid_o), 0);
            end
        end

        // R9: start pulse in the middle of a stalled job
        begin
            int d0;
            d0 = done_cnt;
            push_expect(150);
            @(posedge clk); #1;
            rdy_mode = 0;
            start_i  = 1'b1;
            total_i  = CNT_W'(150);
            @(posedge clk); #1;
            start_i  = 1'b0;
            repeat (2) @(posedge clk);
            #1;
            start_i  = 1'b1;
            total_i  = CNT_W'(5);
            @(posedge clk); #1;
            start_i  = 1'b0;
            rdy_mode = 2;
            wait_done(d0, "R9");
            repeat (4) @(negedge clk);
            check(exp_len.size() == 0 && !strip_valid_o, "R9", "queue after busy start",
                  exp_len.size(), 0);
        end

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "R4", "watchdog expired", 0, 1);
        finish_run();
    end

endmodule